// File: doc/BRIEF.md
# Pulse Insert/Delete Clock Stage

This stage produces a correctable clock for an all-digital phase-locked loop. A reference tick-enable, running at twice the nominal output rate, normally toggles the output once per tick. The output therefore runs at half the reference tick rate. If the reference is 2N times the loop centre frequency, an external divide-by-N counter fed from this output sits at the centre frequency, shifted by the corrections this stage applies.

Two kinds of correction exist. An advance request adds one complete extra output pulse. A retard request removes one pulse. Requests are single-cycle strobes and are held in pending flags until they are serviced. While the loop is locked, advances and retards alternate, so they cancel over time. For a ripple-cancelling loop arrangement, a mode input can take the requests from a second pair of strobes instead of the first pair. Everything runs on one system clock, with ticks given as clock enables.

Top module: `pid_stage`

## Requirements
- R1: While reset is asserted, and after reset is released until the first tick, `stage_out` is 0 and no correction is pending.
- R2: When no correction is pending or in progress, `stage_out` inverts on every clock cycle that has `ref_tick` high. It holds on every other cycle, so it runs at half the tick rate (20 ticks from reset give 10 rising edges and end low).
- R3: A serviced advance adds one output pulse. The normal toggle happens on the servicing tick, and two extra toggles follow on the next two clock cycles, which makes a one-clock-wide level. Ticks must be at least three clock cycles apart.
- R4: A serviced retard removes one output pulse. The toggle is suppressed on the servicing tick and on the next tick.
- R5: A request strobe sets a pending flag. That flag is serviced on the first later tick on which no correction is still in progress. Several requests of one kind that arrive before service count as one.
- R6: If an advance and a retard are both pending when a tick services them, both flags clear and the output makes only its normal toggle.
- R7: When `jk_mode` is 1, `j_req` acts as the advance request and `k_req` acts as the retard request, and `carry_req`/`borrow_req` are ignored. When `jk_mode` is 0, the roles are swapped back.
- R8: One advance followed later by one retard leaves the total count of output pulses equal to the uncorrected count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ref_tick | input | 1 | Reference tick enable, twice the nominal output rate |
| carry_req | input | 1 | Advance request strobe (jk_mode = 0) |
| borrow_req | input | 1 | Retard request strobe (jk_mode = 0) |
| j_req | input | 1 | Advance request strobe (jk_mode = 1) |
| k_req | input | 1 | Retard request strobe (jk_mode = 1) |
| jk_mode | input | 1 | Selects the request pair |
| stage_out | output | 1 | Corrected output clock |

## Verification
An advance and a retard can be pending on the same servicing tick. The bench provokes this by pulsing both request strobes in the same clock cycle. It judges the result by counting rising edges over a fixed 20-tick run, which must match the uncorrected count of 10. A second collision is two strobes of one kind before service. These must add exactly one pulse, so the count is 11 rather than 12.

// File: rtl/pid_pkg.sv
package pid_pkg;
  typedef struct packed {
    logic add;
    logic drop;
  } corr_t;
endpackage

// File: rtl/pid_rst_sync.sv
module pid_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/pid_req_sel.sv
module pid_req_sel
  import pid_pkg::*;
(
  input  logic  jk_mode,
  input  logic  carry_req,
  input  logic  borrow_req,
  input  logic  j_req,
  input  logic  k_req,
  output corr_t req
);
  always_comb begin
    if (jk_mode) begin
      req.add  = j_req;
      req.drop = k_req;
    end else begin
      req.add  = carry_req;
      req.drop = borrow_req;
    end
  end
endmodule

// File: rtl/pid_pend.sv
module pid_pend
  import pid_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  corr_t req,
  input  logic  service,
  output corr_t pend
);
  corr_t pend_q, pend_d;

  always_comb begin
    pend_d = pend_q;
    if (service) pend_d = '0;
    pend_d.add  = pend_d.add  | req.add;
    pend_d.drop = pend_d.drop | req.drop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend = pend_q;
endmodule

// File: rtl/pid_toggle.sv
module pid_toggle
  import pid_pkg::*;
#(
  parameter int INS_TOGGLES = 2,
  parameter int DEL_TICKS   = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick,
  input  corr_t pend,
  output logic  service,
  output logic  ins_busy,
  output logic  del_busy,
  output logic  out
);
  localparam int INS_W = $clog2(INS_TOGGLES + 1);
  localparam int DEL_W = $clog2(DEL_TICKS + 1);

  logic [INS_W-1:0] ins_q, ins_d;
  logic [DEL_W-1:0] del_q, del_d;
  logic             out_q, out_d;
  logic             do_add, do_drop;

  assign ins_busy = (ins_q != '0);
  assign del_busy = (del_q != '0);
  assign service  = tick && !ins_busy && !del_busy;
  assign do_add   = service && pend.add  && !pend.drop;
  assign do_drop  = service && pend.drop && !pend.add;

  always_comb begin
    ins_d = ins_q;
    del_d = del_q;
    out_d = out_q;
    if (tick) begin
      if (del_busy) begin
        del_d = del_q - 1'b1;
      end else if (!do_drop) begin
        out_d = ~out_q;
      end
      if (do_add)  ins_d = INS_W'(INS_TOGGLES);
      if (do_drop) del_d = DEL_W'(DEL_TICKS - 1);
    end else if (ins_busy) begin
      out_d = ~out_q;
      ins_d = ins_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ins_q <= '0;
      del_q <= '0;
      out_q <= 1'b0;
    end else begin
      ins_q <= ins_d;
      del_q <= del_d;
      out_q <= out_d;
    end
  end

  assign out = out_q;
endmodule

// File: rtl/pid_stage.sv
module pid_stage
  import pid_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int INS_TOGGLES = 2,
  parameter int DEL_TICKS   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_tick,
  input  logic carry_req,
  input  logic borrow_req,
  input  logic j_req,
  input  logic k_req,
  input  logic jk_mode,
  output logic stage_out
);
  logic  rst_sync_n;
  corr_t sel_req;
  corr_t pend;
  logic  service;
  logic  ins_busy;
  logic  del_busy;

  pid_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  pid_req_sel u_sel (
    .jk_mode(jk_mode), .carry_req(carry_req), .borrow_req(borrow_req),
    .j_req(j_req), .k_req(k_req), .req(sel_req)
  );

  pid_pend u_pend (
    .clk(clk), .rst_n(rst_sync_n), .req(sel_req),
    .service(service), .pend(pend)
  );

  pid_toggle #(.INS_TOGGLES(INS_TOGGLES), .DEL_TICKS(DEL_TICKS)) u_tog (
    .clk(clk), .rst_n(rst_sync_n), .tick(ref_tick), .pend(pend),
    .service(service), .ins_busy(ins_busy), .del_busy(del_busy),
    .out(stage_out)
  );
endmodule

// File: rtl/pid_stage_chk.sv
module pid_stage_chk (
  input logic clk,
  input logic rst_sync_n,
  input logic tick,
  input logic req_add,
  input logic req_drop,
  input logic p_add,
  input logic p_drop,
  input logic service,
  input logic ins_busy,
  input logic del_busy,
  input logic out
);
  logic idle;
  assign idle = !ins_busy && !del_busy;

  // R1: out low while held in reset
  always @(posedge clk) if (!rst_sync_n) p_reset_low_r1: assert (out == 1'b0);

  p_idle_toggle_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tick && idle && (p_add == p_drop)) |=> (out != $past(out)));

  p_hold_between_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!tick && !ins_busy) |=> $stable(out));

  p_add_starts_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (service && p_add && !p_drop) |=> ins_busy);

  p_drop_holds_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (service && p_drop && !p_add) |=> ($stable(out) && del_busy));

  p_req_latch_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_add && !req_drop) |=> p_add);

  p_cancel_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (service && p_add && p_drop && !req_add && !req_drop) |=> (!p_add && !p_drop && idle));
endmodule

bind pid_stage pid_stage_chk u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .tick(ref_tick),
  .req_add(sel_req.add), .req_drop(sel_req.drop),
  .p_add(pend.add), .p_drop(pend.drop), .service(service),
  .ins_busy(ins_busy), .del_busy(del_busy), .out(stage_out)
);

// File: tb/pid_stage_test.sv
module pid_stage_test;
  logic clk = 1'b0;
  logic rst_n, ref_tick, carry_req, borrow_req, j_req, k_req, jk_mode;
  logic stage_out;

  int n_checks = 0;
  int n_fail   = 0;
  int rises, run, min_run;
  logic prev, seen;

  always #10 clk = ~clk;

  pid_stage uut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .carry_req(carry_req),
    .borrow_req(borrow_req), .j_req(j_req), .k_req(k_req),
    .jk_mode(jk_mode), .stage_out(stage_out)
  );

  always @(negedge clk) begin
    if (stage_out && !prev) rises++;
    if (stage_out == prev) run++;
    else begin
      if (seen && run < min_run) min_run = run;
      seen = 1'b1;
      run  = 1;
    end
    prev = stage_out;
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic restart(input logic mode);
    @(negedge clk);
    rst_n = 1'b0; ref_tick = 0; carry_req = 0; borrow_req = 0;
    j_req = 0; k_req = 0; jk_mode = mode;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rises = 0; run = 0; min_run = 1000; seen = 1'b0; prev = stage_out;
  endtask

  // one tick, then requests r1 and r2 ({k,j,borrow,carry}) on the two following clocks
  task automatic step(input logic [3:0] r1, input logic [3:0] r2);
    @(negedge clk) ref_tick = 1'b1;
    @(negedge clk) ref_tick = 1'b0;
    {k_req, j_req, borrow_req, carry_req} = r1;
    @(negedge clk) {k_req, j_req, borrow_req, carry_req} = r2;
    @(negedge clk) {k_req, j_req, borrow_req, carry_req} = 4'b0;
  endtask

  task automatic run20(input logic [3:0] ra, input logic [3:0] rb,
                       input logic [3:0] late);
    for (int i = 0; i < 20; i++) begin
      if (i == 2)       step(ra, rb);
      else if (i == 8)  step(late, 4'b0);
      else              step(4'b0, 4'b0);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst_n = 1'b0; ref_tick = 0; carry_req = 0; borrow_req = 0;
    j_req = 0; k_req = 0; jk_mode = 0;
    repeat (2) @(negedge clk);
    check("R1 out in reset", int'(stage_out), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 out after release", int'(stage_out), 0);
  endtask

  task automatic t_idle;
    restart(1'b0);
    run20(4'b0, 4'b0, 4'b0);
    check("R2 idle rises", rises, 10);
    check("R2 idle end level", int'(stage_out), 0);
    check("R2 idle min run", min_run, 4);
  endtask

  task automatic t_carry;
    restart(1'b0);
    run20(4'b0001, 4'b0, 4'b0);
    check("R3 carry rises", rises, 11);
    check("R3 carry narrow level", min_run, 1);
  endtask

  task automatic t_borrow;
    restart(1'b0);
    run20(4'b0010, 4'b0, 4'b0);
    check("R4 borrow rises", rises, 9);
  endtask

  task automatic t_dup;
    restart(1'b0);
    run20(4'b0001, 4'b0001, 4'b0);
    check("R5 duplicate carry rises", rises, 11);
  endtask

  task automatic t_both;
    restart(1'b0);
    run20(4'b0011, 4'b0, 4'b0);
    check("R6 both pending rises", rises, 10);
  endtask

  task automatic t_jk;
    restart(1'b1);
    run20(4'b0100, 4'b0, 4'b0);
    check("R7 jk mode j rises", rises, 11);
    restart(1'b1);
    run20(4'b1000, 4'b0, 4'b0);
    check("R7 jk mode k rises", rises, 9);
    restart(1'b1);
    run20(4'b0001, 4'b0, 4'b0);
    check("R7 jk mode carry ignored", rises, 10);
    restart(1'b0);
    run20(4'b0100, 4'b0, 4'b0);
    check("R7 normal mode j ignored", rises, 10);
  endtask

  task automatic t_alt;
    restart(1'b0);
    run20(4'b0001, 4'b0, 4'b0010);
    check("R8 carry then borrow rises", rises, 10);
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    prev = 1'b0; seen = 1'b0; run = 0; min_run = 1000; rises = 0;
    t_reset();
    t_idle();
    t_carry();
    t_borrow();
    t_dup();
    t_both();
    t_jk();
    t_alt();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule